// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Tick Prescaler

This block is a byte-programmable timer/counter of the classic microcontroller kind. Its count is held in a low byte and a high byte. A 2-bit mode field arranges the two bytes as one of four counters: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, or two separate 8-bit counters. Each count step comes from one of two sources. The first is an internal tick from a prescaler that divides the system clock by 12, 4 or 13. The second is a falling edge on an external count pin, taken through a synchronizer.

Software drives the block through a simple register port. A write port and a combinational read port each take a 2-bit address. Address 0 holds the control byte, address 1 the low count byte and address 2 the high count byte. Address 3 reads as zero. The control byte is laid out as follows:

- bits [1:0]: mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split)
- bit 2: run
- bit 3: count source (1 = external pin)
- bit 4: divide-by-4
- bit 5: divide-by-13
- bit 6: overflow flag
- bit 7: second overflow flag, used by split mode

Any write to the control byte restarts the prescaler phase.

Top module: `timer_unit`

## Requirements
- R1: After reset, all three registers read 0x00. This means mode 0, stopped, internal ticks and divide-by-12. Address 3 always reads 0x00.
- R2: With bits 4 and 5 clear, one increment happens per 12 clocks. The first increment is visible after the 12th clock edge that follows the edge capturing the control write.
- R3: With bit 4 set and bit 5 clear, one increment happens per 4 clocks. The first increment is visible after the 4th edge.
- R4: Bit 5 selects divide-by-13 regardless of bit 4. The first increment is visible after the 13th edge.
- R5: In mode 0, bits [4:0] of the low byte count. When they wrap, the high byte is incremented. Low bits [7:5] are left unchanged. The wrap from 0x1FFF to 0 sets bit 6.
- R6: In mode 1, {high,low} counts as 16 bits. The wrap from 0xFFFF to 0x0000 sets bit 6.
- R7: In mode 2, the low byte counts. When it steps from 0xFF, it loads the high byte's value instead of wrapping, and bit 6 is set. The high byte is unchanged.
- R8: In mode 3, the low byte counts the selected source and sets bit 6 when it wraps from 0xFF. The high byte always counts prescaled ticks while run is set, and sets bit 7 when it wraps from 0xFF.
- R9: With bit 3 set, the count source is falling edges on cnt_pin_i (high then low) instead of ticks. The increment is visible after the 3rd clock edge following the pin's fall. Rising edges and a static pin do not count.
- R10: While run (bit 2) is 0, both count bytes hold their values.
- R11: Bits 6 and 7 are sticky. A control write with 0 in a flag bit clears that flag. A write with 1 leaves the flag unchanged and never sets it.
- R12: A write to a count byte is visible after the capturing edge. It takes precedence over an increment due on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 low, 2 high) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| cnt_pin_i | input | 1 | External count input, asynchronous |

## Verification
Register writes are due right after the edge that captures them. A prescaled increment is due on the 12th, 4th or 13th edge after the control write, because that write restarts the prescaler. A pin-driven increment is due on the 3rd edge after the pin falls: two synchronizer flops and one history flop. Each directed task counts exact edges from its stimulus and reads 1 ns after an edge. It checks the edge just before each deadline as well as the deadline itself, so an off-by-one in the prescaler or the synchronizer chain shows up as a wrong value.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the timer/counter.
// Assumes an 8-bit register port and a fixed control-byte layout.
package tmr_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MODE_13     = 2'd0,
        MODE_16     = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOW  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd2;

    localparam int B_RUN  = 2;
    localparam int B_EXT  = 3;
    localparam int B_FAST = 4;
    localparam int B_ALT  = 5;
    localparam int B_OVF  = 6;
    localparam int B_OVF2 = 7;

endpackage

// File: rtl/tmr_prescaler.sv
// Tick prescaler: one-cycle tick every DIV_BASE, DIV_FAST or DIV_ALT clocks.
// The alternate divisor overrides the fast one. restart_i zeroes the phase,
// and no tick is issued in the restart cycle. Assumes every divisor is >= 2.
module tmr_prescaler #(
    parameter int DIV_BASE = 12,
    parameter int DIV_FAST = 4,
    parameter int DIV_ALT  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic fast_i,
    input  logic alt_i,
    output logic tick_o
);
    localparam int MAX1 = (DIV_BASE > DIV_FAST) ? DIV_BASE : DIV_FAST;
    localparam int MAXD = (MAX1 > DIV_ALT) ? MAX1 : DIV_ALT;
    localparam int CW   = $clog2(MAXD);
    localparam logic [CW-1:0] LAST_BASE = CW'(DIV_BASE - 1);
    localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] LAST_ALT  = CW'(DIV_ALT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Pick the terminal phase count for the active divisor.
    always_comb begin
        if (alt_i)       last = LAST_ALT;
        else if (fast_i) last = LAST_FAST;
        else             last = LAST_BASE;
    end

    // Tick on the terminal phase, except in a restart cycle.
    always_comb tick_o = !restart_i && (cnt_q >= last);

    // Phase counter: cleared on reset, restart or tick, else advances.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || tick_o) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tmr_edge_sync.sv
// External pin synchronizer with falling-edge detect. STAGES flops
// synchronize the pin, and one more flop keeps the previous sample.
// fall_o is a one-cycle pulse. Assumes the pin idles high; the chain resets high.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    // Shift the raw pin through the synchronizer and history chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], pin_i};
    end

    // Falling edge: older sample high, newer sample low.
    always_comb fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_count_core.sv
// Count register pair and mode datapath. A count step applies when
// run_i && inc_i. In split mode (when SPLIT_EN is set) the high byte steps on
// run_i && tick_i. Software writes to either byte take precedence over a step.
// ovf_o and ovf2_o are one-cycle wrap pulses.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int M0_LOW   = 5,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode_i,
    input  logic             run_i,
    input  logic             inc_i,
    input  logic             tick_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] lo_o,
    output logic [REG_W-1:0] hi_o,
    output logic             ovf_o,
    output logic             ovf2_o
);
    logic [REG_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic             step;
    logic             split_lo_step, split_hi_step;

    // Main count step from the selected source.
    always_comb step = run_i & inc_i;

    // Split-mode step enables exist only when the variant is built in.
    generate
        if (SPLIT_EN) begin : g_split
            assign split_lo_step = (mode_i == MODE_SPLIT) & step;
            assign split_hi_step = (mode_i == MODE_SPLIT) & run_i & tick_i;
        end else begin : g_nosplit
            assign split_lo_step = 1'b0;
            assign split_hi_step = 1'b0;
        end
    endgenerate

    // Next-count and wrap logic for each mode.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf_o  = 1'b0;
        ovf2_o = 1'b0;
        case (mode_i)
            MODE_13: if (step) begin
                lo_n[M0_LOW-1:0] = lo_q[M0_LOW-1:0] + 1'b1;
                if (&lo_q[M0_LOW-1:0]) begin
                    hi_n  = hi_q + 1'b1;
                    ovf_o = &hi_q;
                end
            end
            MODE_16: if (step) begin
                {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                ovf_o        = &{hi_q, lo_q};
            end
            MODE_RELOAD: if (step) begin
                if (&lo_q) begin
                    lo_n  = hi_q;
                    ovf_o = 1'b1;
                end else begin
                    lo_n = lo_q + 1'b1;
                end
            end
            MODE_SPLIT: begin
                if (split_lo_step) begin
                    lo_n  = lo_q + 1'b1;
                    ovf_o = &lo_q;
                end
                if (split_hi_step) begin
                    hi_n   = hi_q + 1'b1;
                    ovf2_o = &hi_q;
                end
            end
        endcase
    end

    // Count registers: a software write beats the computed step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wr_lo_i ? wr_data_i : lo_n;
            hi_q <= wr_hi_i ? wr_data_i : hi_n;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
    a_r6_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_16 && ovf_o && !wr_lo_i && !wr_hi_i) |=> (lo_q == '0 && hi_q == '0));
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RELOAD && ovf_o && !wr_lo_i && !wr_hi_i) |=> (lo_q == $past(hi_q)));
    a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_13 && !wr_lo_i) |=> (lo_q[REG_W-1:M0_LOW] == $past(lo_q[REG_W-1:M0_LOW])));
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (lo_q == $past(wr_data_i)));

endmodule

// File: rtl/timer_unit.sv
// Top of the timer/counter. Holds the control byte and the sticky flags,
// decodes the register port, and selects the count source (prescaled tick
// or synchronized pin fall). Assumes a single software writer.
module timer_unit
    import tmr_pkg::*;
#(
    parameter int DIV_BASE    = 12,
    parameter int DIV_FAST    = 4,
    parameter int DIV_ALT     = 13,
    parameter int SYNC_STAGES = 2,
    parameter int M0_LOW      = 5,
    parameter bit SPLIT_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              cnt_pin_i
);
    tmr_mode_e        mode_q;
    logic             run_q, ext_q, fast_q, alt_q, ovf_q, ovf2_q;
    logic             ctrl_wr, tick, pin_fall, inc;
    logic             ovf_set, ovf2_set;
    logic [REG_W-1:0] lo, hi;

    // Control write decode.
    always_comb ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);

    // Control fields; the flags are set by hardware and cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_13;
            run_q  <= 1'b0;
            ext_q  <= 1'b0;
            fast_q <= 1'b0;
            alt_q  <= 1'b0;
            ovf_q  <= 1'b0;
            ovf2_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                mode_q <= tmr_mode_e'(wr_data_i[1:0]);
                run_q  <= wr_data_i[B_RUN];
                ext_q  <= wr_data_i[B_EXT];
                fast_q <= wr_data_i[B_FAST];
                alt_q  <= wr_data_i[B_ALT];
            end
            ovf_q  <= ovf_set  | (ovf_q  & (!ctrl_wr | wr_data_i[B_OVF]));
            ovf2_q <= ovf2_set | (ovf2_q & (!ctrl_wr | wr_data_i[B_OVF2]));
        end
    end

    tmr_prescaler #(
        .DIV_BASE (DIV_BASE),
        .DIV_FAST (DIV_FAST),
        .DIV_ALT  (DIV_ALT)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_wr),
        .fast_i    (fast_q),
        .alt_i     (alt_q),
        .tick_o    (tick)
    );

    tmr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_pin_i),
        .fall_o (pin_fall)
    );

    // Count source select: pin falls in counter mode, prescaled ticks otherwise.
    always_comb inc = ext_q ? pin_fall : tick;

    tmr_count_core #(
        .M0_LOW   (M0_LOW),
        .SPLIT_EN (SPLIT_EN)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_q),
        .run_i     (run_q),
        .inc_i     (inc),
        .tick_i    (tick),
        .wr_lo_i   (wr_en_i && (wr_addr_i == A_LOW)),
        .wr_hi_i   (wr_en_i && (wr_addr_i == A_HIGH)),
        .wr_data_i (wr_data_i),
        .lo_o      (lo),
        .hi_o      (hi),
        .ovf_o     (ovf_set),
        .ovf2_o    (ovf2_set)
    );

    // Combinational register read mux.
    always_comb begin
        case (rd_addr_i)
            A_CTRL:  rd_data_o = {ovf2_q, ovf_q, alt_q, fast_q, ext_q, run_q, mode_q};
            A_LOW:   rd_data_o = lo;
            A_HIGH:  rd_data_o = hi;
            default: rd_data_o = '0;
        endcase
    end

    a_r11_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ctrl_wr) |=> ovf_q);
    a_r11_sticky_ovf2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf2_q && !ctrl_wr) |=> ovf2_q);

endmodule

// File: tb/test_timer_unit.sv
// Directed bench for timer_unit: one task per scenario, each self-checking.
module test_timer_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pin = 1'b1;
    int         checks = 0;
    int         failures = 0;

    timer_unit i_timer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .cnt_pin_i (pin)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Stop, load both count bytes, then write the control byte (edge E0).
    task automatic setup(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ctrl);
        wr(2'd0, 8'h00);
        wr(2'd1, lo);
        wr(2'd2, hi);
        wr(2'd0, ctrl);
    endtask

    task automatic t_reset;
        chk("R1", "ctrl", 2'd0, 8'h00);
        chk("R1", "low",  2'd1, 8'h00);
        chk("R1", "high", 2'd2, 8'h00);
        chk("R1", "addr3", 2'd3, 8'h00);
    endtask

    task automatic t_div12;
        setup(8'h00, 8'h00, 8'h05);
        edges(11); chk("R2", "before 12th edge", 2'd1, 8'h00);
        edges(1);  chk("R2", "at 12th edge", 2'd1, 8'h01);
        edges(12); chk("R2", "at 24th edge", 2'd1, 8'h02);
    endtask

    task automatic t_div4;
        setup(8'h00, 8'h00, 8'h15);
        edges(3);  chk("R3", "before 4th edge", 2'd1, 8'h00);
        edges(1);  chk("R3", "at 4th edge", 2'd1, 8'h01);
        edges(36); chk("R3", "at 40th edge", 2'd1, 8'h0A);
    endtask

    task automatic t_div13;
        setup(8'h00, 8'h00, 8'h35);
        edges(12); chk("R4", "before 13th edge", 2'd1, 8'h00);
        edges(1);  chk("R4", "at 13th edge", 2'd1, 8'h01);
    endtask

    task automatic t_mode13;
        setup(8'hFF, 8'hFF, 8'h14);
        edges(4);
        chk("R5", "low after wrap", 2'd1, 8'hE0);
        chk("R5", "high after wrap", 2'd2, 8'h00);
        chk("R5", "flag set", 2'd0, 8'h54);
        setup(8'h3F, 8'h12, 8'h14);
        edges(4);
        chk("R5", "low carry", 2'd1, 8'h20);
        chk("R5", "high carry", 2'd2, 8'h13);
        chk("R5", "no flag", 2'd0, 8'h14);
    endtask

    task automatic t_mode16;
        setup(8'hFF, 8'h12, 8'h15);
        edges(4);
        chk("R6", "low carry", 2'd1, 8'h00);
        chk("R6", "high carry", 2'd2, 8'h13);
        chk("R6", "no flag", 2'd0, 8'h15);
        setup(8'hFF, 8'hFF, 8'h15);
        edges(4);
        chk("R6", "low wrap", 2'd1, 8'h00);
        chk("R6", "high wrap", 2'd2, 8'h00);
        chk("R6", "flag", 2'd0, 8'h55);
    endtask

    task automatic t_reload_and_flags;
        setup(8'hFE, 8'h80, 8'h16);
        edges(4); chk("R7", "pre-wrap", 2'd1, 8'hFF);
        edges(4); chk("R7", "reloaded", 2'd1, 8'h80);
        chk("R7", "flag", 2'd0, 8'h56);
        edges(4); chk("R7", "after reload", 2'd1, 8'h81);
        chk("R7", "high untouched", 2'd2, 8'h80);
        wr(2'd0, 8'h56); chk("R11", "write 1 keeps flag", 2'd0, 8'h56);
        wr(2'd0, 8'h16); chk("R11", "write 0 clears flag", 2'd0, 8'h16);
        wr(2'd0, 8'hC0); chk("R11", "write 1 does not set", 2'd0, 8'h00);
    endtask

    task automatic t_split;
        setup(8'hFF, 8'hFE, 8'h17);
        edges(4);
        chk("R8", "low wrap", 2'd1, 8'h00);
        chk("R8", "high step", 2'd2, 8'hFF);
        chk("R8", "low flag", 2'd0, 8'h57);
        edges(4);
        chk("R8", "high wrap", 2'd2, 8'h00);
        chk("R8", "both flags", 2'd0, 8'hD7);
        setup(8'h10, 8'h10, 8'h1F);
        edges(8);
        chk("R8", "low idle on pin", 2'd1, 8'h10);
        chk("R8", "high on ticks", 2'd2, 8'h12);
    endtask

    task automatic t_counter_pin;
        setup(8'h00, 8'h00, 8'h0D);
        pin = 1'b0;
        edges(2);  chk("R9", "before 3rd edge", 2'd1, 8'h00);
        edges(1);  chk("R9", "at 3rd edge", 2'd1, 8'h01);
        pin = 1'b1;
        edges(30); chk("R9", "rise and ticks ignored", 2'd1, 8'h01);
        pin = 1'b0;
        edges(3);  chk("R9", "second fall", 2'd1, 8'h02);
        pin = 1'b1;
        edges(3);
    endtask

    task automatic t_stopped;
        setup(8'h05, 8'h07, 8'h11);
        edges(20);
        chk("R10", "low held", 2'd1, 8'h05);
        chk("R10", "high held", 2'd2, 8'h07);
    endtask

    task automatic t_write_wins;
        setup(8'h00, 8'h00, 8'h15);
        edges(3);
        wr(2'd1, 8'h40);
        chk("R12", "write beats step", 2'd1, 8'h40);
        edges(4);
        chk("R12", "next step", 2'd1, 8'h41);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_div12();
        t_div4();
        t_div13();
        t_mode13();
        t_mode16();
        t_reload_and_flags();
        t_split();
        t_counter_pin();
        t_stopped();
        t_write_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule